// File: doc/BRIEF.md
# Cache Line Sharing Profiler

This block sits beside a shared last-level cache and watches the events the cache reports. Each event carries a requesting core, an operation (access, fill or eviction), a write flag, a hit flag and the index of the line slot involved. For every slot the block keeps three things: a bitmap of the cores that have touched the resident line, the core that touched it most recently, and a flag that is set once the line has been written. All of this state covers only the line's current stay in the cache.

Each access hit is classified using the slot state after that access has been applied. A hit is private or shared. A shared hit is also tagged as active-shared, as touching read-write shared data, and by its exact sharer count. Every access increments a bank of saturating statistics counters. A retired-instruction counter decides when a snapshot is taken. At that moment all live counters are copied into a holding bank and restarted in the same cycle. Software reads the holding bank through a select/data pair.

Top module: `share_profiler`

## Requirements
- R1: A fill sets the slot's sharer bitmap to the filling core alone and makes that core the last accessor. It sets the slot's written flag equal to the fill's write flag. The fill itself is not counted as an access.
- R2: An eviction clears the slot's bitmap, last accessor and written flag. A later hit on that slot starts from empty history, so the first hit is private and is never active-shared.
- R3: A hit is shared when the bitmap, including the requesting core, holds more than one core, and private otherwise. Counter 2 counts private hits and counter 3 counts shared hits.
- R4: A shared hit goes into counter 5 (read-write shared) when the written flag, including this access's write, is set. A line with no write so far stays read-only shared.
- R5: A shared hit is active-shared (counter 4) when the slot's previous last accessor differs from the requesting core. The access that first makes a line shared counts as active-shared.
- R6: Each shared hit increments exactly one histogram counter, at index 8 + (sharer count − 2), for sharer counts 2 up to the core count.
- R7: An access with the hit flag low increments counter 1 (misses) and leaves the slot state unchanged. Counter 0 counts every access.
- R8: Counter 6 counts every write access. Counter 7 counts write accesses that are shared hits.
- R9: The retired-instruction input accumulates each cycle. When the total reaches the interval (default 10,000,000), a snapshot is taken and the excess carries into the next interval. `snap_pulse` is high for the one cycle after each snapshot.
- R10: A snapshot copies every live counter into the holding bank and restarts the live counters in the same cycle. An access in the snapshot cycle is counted into the new interval. Between snapshots the holding bank does not change.
- R11: Counters saturate at their all-ones value instead of wrapping.
- R12: `snap_data` returns holding counter `snap_sel`, and reads as zero for a select at or above the counter count. Event operation codes: 0 access, 1 fill, 2 evict, 3 no operation.
- R13: After reset every holding counter reads zero and `snap_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_op | input | 2 | Operation: 0 access, 1 fill, 2 evict, 3 none |
| ev_core | input | $clog2(NCORES) | Requesting core |
| ev_write | input | 1 | Access or fill is a write |
| ev_hit | input | 1 | Access hit in the cache |
| ev_slot | input | $clog2(NSLOTS) | Line slot (set and way) |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| snap_pulse | output | 1 | A snapshot was taken on the last edge |
| snap_sel | input | SEL_W | Holding counter select |
| snap_data | output | CNT_W | Selected holding counter value |

## Verification
The hardest case to reach from the ports is a line that has collected several distinct sharers, a write and a run of alternating owners, all inside one residency. Random traffic over a large slot table rarely builds that. The stimulus therefore replays a fixed core sequence on one filled slot, adds a write, and evicts the slot. It then spreads random traffic over only eight slots with four cores, so high sharer counts and evictions of heavily shared lines happen often. Counter saturation is reached by stopping instruction retirement during a long burst of hits, with a narrow counter width on the bench instance.

// File: rtl/shprof_pkg.sv
`timescale 1ns/1ps
package shprof_pkg;
  typedef enum logic [1:0] {
    EV_ACCESS = 2'd0,
    EV_FILL   = 2'd1,
    EV_EVICT  = 2'd2,
    EV_NONE   = 2'd3
  } ev_op_e;

  localparam int IDX_ACCESS  = 0;
  localparam int IDX_MISS    = 1;
  localparam int IDX_PRIV    = 2;
  localparam int IDX_SHARED  = 3;
  localparam int IDX_ACTIVE  = 4;
  localparam int IDX_RWSH    = 5;
  localparam int IDX_WRITE   = 6;
  localparam int IDX_SHWRITE = 7;
  localparam int IDX_HIST0   = 8;

  function automatic logic [4:0] popcnt16(input logic [15:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + {4'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/shprof_slot_tracker.sv
`timescale 1ns/1ps
module shprof_slot_tracker import shprof_pkg::*; #(
  parameter int NCORES = 4,
  parameter int NSLOTS = 64,
  localparam int CORE_W = $clog2(NCORES),
  localparam int SLOT_W = $clog2(NSLOTS),
  localparam int CNTS_W = $clog2(NCORES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_op,
  input  logic [CORE_W-1:0] ev_core,
  input  logic              ev_write,
  input  logic              ev_hit,
  input  logic [SLOT_W-1:0] ev_slot,
  output logic              hit_acc,
  output logic              cls_shared,
  output logic              cls_active,
  output logic              cls_rw,
  output logic [CNTS_W-1:0] cls_count
);
  logic [NCORES-1:0] map_q  [NSLOTS];
  logic [CORE_W-1:0] last_q [NSLOTS];
  logic              wr_q   [NSLOTS];

  logic [NCORES-1:0] core_bit, new_map;
  logic              new_wr;
  logic [CNTS_W-1:0] count_raw;
  logic              is_fill, is_evict;

  always_comb begin
    core_bit  = NCORES'(1) << ev_core;
    new_map   = map_q[ev_slot] | core_bit;
    new_wr    = wr_q[ev_slot] | ev_write;
    count_raw = CNTS_W'(popcnt16(16'(new_map)));
    is_fill   = ev_valid && (ev_op == EV_FILL);
    is_evict  = ev_valid && (ev_op == EV_EVICT);
    hit_acc   = ev_valid && (ev_op == EV_ACCESS) && ev_hit;
    cls_count  = hit_acc ? count_raw : '0;
    cls_shared = hit_acc && (count_raw > CNTS_W'(1));
    cls_active = cls_shared && (last_q[ev_slot] != ev_core);
    cls_rw     = cls_shared && new_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOTS; s++) begin
        map_q[s]  <= '0;
        last_q[s] <= '0;
        wr_q[s]   <= 1'b0;
      end
    end else if (is_fill) begin
      map_q[ev_slot]  <= core_bit;
      last_q[ev_slot] <= ev_core;
      wr_q[ev_slot]   <= ev_write;
    end else if (is_evict) begin
      map_q[ev_slot]  <= '0;
      last_q[ev_slot] <= '0;
      wr_q[ev_slot]   <= 1'b0;
    end else if (hit_acc) begin
      map_q[ev_slot]  <= new_map;
      last_q[ev_slot] <= ev_core;
      wr_q[ev_slot]   <= new_wr;
    end
  end

  AST_FILL_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    is_fill ##1 (hit_acc && ev_slot == $past(ev_slot) && ev_core == $past(ev_core)) |-> !cls_shared); // R1
  AST_EVICT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    is_evict ##1 (hit_acc && ev_slot == $past(ev_slot)) |-> (cls_count == CNTS_W'(1)) && !cls_active); // R2
  AST_REPEAT_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc ##1 (hit_acc && ev_slot == $past(ev_slot) && ev_core == $past(ev_core)) |-> !cls_active); // R5
endmodule

// File: rtl/shprof_interval.sv
`timescale 1ns/1ps
module shprof_interval #(
  parameter int unsigned INTERVAL = 10_000_000,
  parameter int RET_W = 4,
  localparam int CW = $clog2(INTERVAL + (2 ** RET_W)) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] retire_cnt,
  output logic             snap_fire,
  output logic             snap_pulse
);
  logic [CW-1:0] cnt_q, sum;

  always_comb begin
    sum       = cnt_q + CW'(retire_cnt);
    snap_fire = (sum >= CW'(INTERVAL));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      snap_pulse <= 1'b0;
    end else begin
      cnt_q      <= snap_fire ? (sum - CW'(INTERVAL)) : sum;
      snap_pulse <= snap_fire;
    end
  end

  AST_RESIDUE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(INTERVAL)); // R9

  generate
    if (INTERVAL > (2 ** RET_W)) begin : g_single
      AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse |-> !$past(snap_pulse)); // R9
    end
  endgenerate
endmodule

// File: rtl/shprof_stat_bank.sv
`timescale 1ns/1ps
module shprof_stat_bank #(
  parameter int NCNT  = 11,
  parameter int CNT_W = 48,
  localparam int SEL_W = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_fire,
  input  logic [NCNT-1:0]  inc,
  input  logic [SEL_W-1:0] snap_sel,
  output logic [CNT_W-1:0] snap_data
);
  logic [NCNT-1:0][CNT_W-1:0] live_q, hold_q;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v, input logic bump);
    return (bump && (v != '1)) ? v + CNT_W'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (snap_fire) begin
          hold_q[i] <= live_q[i];
          live_q[i] <= CNT_W'(inc[i]);
        end else begin
          live_q[i] <= sat_step(live_q[i], inc[i]);
        end
      end
    end
  end

  always_comb begin
    snap_data = '0;
    if (int'(snap_sel) < NCNT) snap_data = hold_q[snap_sel];
  end

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_chk
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_fire |=> live_q[g] >= $past(live_q[g])); // R11
      AST_CLEAR_ON_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        snap_fire |=> live_q[g] <= CNT_W'(1)); // R10
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_fire |=> $stable(hold_q[g])); // R10
    end
  endgenerate
endmodule

// File: rtl/share_profiler.sv
`timescale 1ns/1ps
module share_profiler import shprof_pkg::*; #(
  parameter int NCORES = 4,
  parameter int NSLOTS = 64,
  parameter int CNT_W  = 48,
  parameter int RET_W  = 4,
  parameter int unsigned INTERVAL = 10_000_000,
  localparam int CORE_W = $clog2(NCORES),
  localparam int SLOT_W = $clog2(NSLOTS),
  localparam int CNTS_W = $clog2(NCORES + 1),
  localparam int NCNT   = IDX_HIST0 + NCORES - 1,
  localparam int SEL_W  = $clog2(NCNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_op,
  input  logic [CORE_W-1:0] ev_core,
  input  logic              ev_write,
  input  logic              ev_hit,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [RET_W-1:0]  retire_cnt,
  output logic              snap_pulse,
  input  logic [SEL_W-1:0]  snap_sel,
  output logic [CNT_W-1:0]  snap_data
);
  logic              hit_acc, cls_shared, cls_active, cls_rw;
  logic [CNTS_W-1:0] cls_count;
  logic              snap_fire, is_access;
  logic [NCNT-1:0]   inc_vec;

  shprof_slot_tracker #(.NCORES(NCORES), .NSLOTS(NSLOTS)) u_track (
    .clk, .rst_n, .ev_valid, .ev_op, .ev_core, .ev_write, .ev_hit, .ev_slot,
    .hit_acc, .cls_shared, .cls_active, .cls_rw, .cls_count
  );

  shprof_interval #(.INTERVAL(INTERVAL), .RET_W(RET_W)) u_ivl (
    .clk, .rst_n, .retire_cnt, .snap_fire, .snap_pulse
  );

  assign is_access = ev_valid && (ev_op == EV_ACCESS);

  always_comb begin
    inc_vec[IDX_ACCESS]  = is_access;
    inc_vec[IDX_MISS]    = is_access && !ev_hit;
    inc_vec[IDX_PRIV]    = hit_acc && !cls_shared;
    inc_vec[IDX_SHARED]  = cls_shared;
    inc_vec[IDX_ACTIVE]  = cls_active;
    inc_vec[IDX_RWSH]    = cls_rw;
    inc_vec[IDX_WRITE]   = is_access && ev_write;
    inc_vec[IDX_SHWRITE] = cls_shared && ev_write;
  end

  generate
    for (genvar k = 2; k <= NCORES; k++) begin : g_hist
      assign inc_vec[IDX_HIST0 + k - 2] = cls_shared && (cls_count == CNTS_W'(k));
    end
  endgenerate

  shprof_stat_bank #(.NCNT(NCNT), .CNT_W(CNT_W)) u_bank (
    .clk, .rst_n, .snap_fire, .inc(inc_vec), .snap_sel, .snap_data
  );

  AST_HIST_ONE_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    cls_shared |-> $countones(inc_vec[NCNT-1:IDX_HIST0]) == 1); // R6
  AST_MISS_NOT_CLASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_access && !ev_hit) |-> !cls_shared && !cls_active); // R7
endmodule

// File: tb/share_profiler_test.sv
`timescale 1ns/1ps
module share_profiler_test;
  localparam int NC = 4, NS = 64, CW = 6, RW = 2, IV = 40;
  localparam int NCNT = 8 + NC - 1;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_write = 0, ev_hit = 0;
  logic [1:0] ev_op = 2'd3;
  logic [1:0] ev_core = 0;
  logic [5:0] ev_slot = 0;
  logic [RW-1:0] retire_cnt = 0;
  logic snap_pulse;
  logic [3:0] snap_sel = 0;
  logic [CW-1:0] snap_data;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R13_reset";

  // reference state
  int m_map[NS], m_last[NS], m_wr[NS];
  int m_live[NCNT], m_hold[NCNT];
  int m_cnt = 0, m_pulse = 0;

  share_profiler #(.NCORES(NC), .NSLOTS(NS), .CNT_W(CW), .RET_W(RW), .INTERVAL(IV)) uut (
    .clk, .rst_n, .ev_valid, .ev_op, .ev_core, .ev_write, .ev_hit, .ev_slot,
    .retire_cnt, .snap_pulse, .snap_sel, .snap_data
  );

  always #10 clk = ~clk;

  function automatic string req_of(int i);
    case (i)
      0: return "R12"; 1: return "R7"; 2: return "R3"; 3: return "R3";
      4: return "R5";  5: return "R4"; 6: return "R8"; 7: return "R8";
      default: return (i < NCNT) ? "R6" : "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_map[s]) begin m_map[s] = 0; m_last[s] = 0; m_wr[s] = 0; end
      foreach (m_live[i]) begin m_live[i] = 0; m_hold[i] = 0; end
      m_cnt = 0; m_pulse = 0;
    end else begin
      int inc[NCNT];
      int s, c, nm, nw, n, sum;
      foreach (inc[i]) inc[i] = 0;
      s = ev_slot; c = ev_core;
      if (ev_valid && ev_op == 2'd0) begin
        inc[0] = 1;
        if (ev_write) inc[6] = 1;
        if (!ev_hit) inc[1] = 1;
        else begin
          nm = m_map[s] | (1 << c);
          nw = m_wr[s] | ev_write;
          n = 0;
          for (int b = 0; b < NC; b++) if (nm & (1 << b)) n++;
          if (n > 1) begin
            inc[3] = 1;
            if (m_last[s] != c) inc[4] = 1;
            if (nw) inc[5] = 1;
            if (ev_write) inc[7] = 1;
            inc[8 + n - 2] = 1;
          end else inc[2] = 1;
          m_map[s] = nm; m_wr[s] = nw; m_last[s] = c;
        end
      end else if (ev_valid && ev_op == 2'd1) begin
        m_map[s] = 1 << c; m_last[s] = c; m_wr[s] = ev_write;
      end else if (ev_valid && ev_op == 2'd2) begin
        m_map[s] = 0; m_last[s] = 0; m_wr[s] = 0;
      end
      sum = m_cnt + retire_cnt;
      if (sum >= IV) begin
        foreach (m_live[i]) begin m_hold[i] = m_live[i]; m_live[i] = inc[i]; end
        m_cnt = sum - IV; m_pulse = 1;
      end else begin
        foreach (m_live[i]) m_live[i] = (m_live[i] + inc[i] > MAXV) ? MAXV : m_live[i] + inc[i];
        m_cnt = sum; m_pulse = 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  task automatic compare(bit full);
    check(snap_pulse == m_pulse, "R9", snap_pulse, m_pulse);
    if (full || m_pulse) begin
      for (int i = 0; i <= NCNT; i++) begin
        int e;
        snap_sel = 4'(i);
        #0.5;
        e = (i < NCNT) ? m_hold[i] : 0;
        check(int'(snap_data) == e, req_of(i), snap_data, e);
      end
    end else begin
      int e;
      e = (int'(snap_sel) < NCNT) ? m_hold[snap_sel] : 0;
      check(int'(snap_data) == e, "R10", snap_data, e);
    end
  endtask

  task automatic step(bit v, int op, int core, bit wr, bit hit, int slot, int ret);
    @(negedge clk);
    compare(0);
    ev_valid = v; ev_op = 2'(op); ev_core = 2'(core); ev_write = wr;
    ev_hit = hit; ev_slot = 6'(slot); retire_cnt = RW'(ret);
  endtask

  initial begin
    int seq[13] = '{1, 2, 2, 2, 1, 3, 0, 3, 2, 2, 2, 3, 2};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare(1); // R13 reset state
    phase = "R1_fill";
    step(1, 1, 1, 0, 0, 5, $urandom_range(0, 3));
    repeat (3) step(1, 0, 1, 0, 1, 5, $urandom_range(0, 3));
    step(1, 1, 2, 1, 0, 6, 1);
    step(1, 0, 2, 0, 1, 6, 1);
    step(1, 0, 3, 0, 1, 6, 1);
    phase = "R5_example";
    foreach (seq[i]) step(1, 0, seq[i], 0, 1, 5, $urandom_range(0, 3));
    phase = "R4_rw";
    step(1, 0, 0, 0, 1, 5, 1);
    step(1, 0, 3, 1, 1, 5, 1);
    repeat (2) step(1, 0, 1, 0, 1, 5, 1);
    phase = "R2_evict";
    step(1, 2, 0, 0, 0, 5, 1);
    step(1, 0, 0, 0, 1, 5, 1);
    step(1, 0, 0, 0, 1, 5, 1);
    step(1, 0, 1, 0, 1, 5, 1);
    phase = "R7_miss";
    for (int i = 0; i < 20; i++) step(1, 0, i % 4, i[0], 0, 5, 2);
    phase = "R12_idle";
    for (int i = 0; i < 10; i++) step(i[0], 3, 1, 1, 1, 5, 3);
    phase = "R10_random";
    for (int i = 0; i < 4000; i++) begin
      int r, slot;
      r = $urandom_range(0, 99);
      slot = ($urandom_range(0, 9) == 0) ? 63 : $urandom_range(0, 7);
      step(r < 95, (r < 8) ? 1 : (r < 14) ? 2 : (r < 17) ? 3 : 0,
           $urandom_range(0, 3), $urandom_range(0, 3) == 0,
           $urandom_range(0, 5) != 0, slot, $urandom_range(0, 3));
    end
    phase = "R11_sat";
    for (int i = 0; i < 90; i++) step(1, 0, i % 4, i[1], 1, 2, 0);
    for (int i = 0; i < 60; i++) step(0, 0, 0, 0, 0, 0, 3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (%s) actual=hung expected=done", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule